// File: doc/BRIEF.md
# Privileged Debug Register Access Unit

This unit holds eight 32-bit debug register slots and serves the two move instructions that copy a debug register to a general-purpose register, or a general-purpose register to a debug register. A simple instruction decoder presents one decoded request per cycle. The request carries a direction bit, the ModR/M byte, the current privilege level, a real-address-mode flag and a debug-extension enable flag. A write also carries 32-bit data from the general-purpose register file. In the same cycle the unit returns the read data, the index of the general-purpose register to load, a write-enable for that register and a fault code.

Every access is gated by privilege. The mode of register indices 4 and 5 depends on the debug-extension flag. With the flag clear, these indices fold onto registers 6 and 7. With the flag set, naming either index raises an undefined-opcode fault. A faulting request changes no state and produces no general-purpose write.

The request side follows valid/ready rules. `req_ready` is held high, so the unit never applies back-pressure: each cycle with `req_valid` high is one accepted request. The response is combinational, is qualified by `rsp_valid` in the same cycle, and cannot be stalled. A consumer must take it in that cycle.

Top module: `dbgreg_access_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight debug registers to zero.
- R2: Every transfer moves all 32 bits unchanged, with no operand-size narrowing; for example, 0xFFFFFFFF and 0x80000001 read back exactly.
- R3: ModR/M bits [5:3] select the debug register, and bits [2:0] appear on `rsp_gpr_idx` for every valid request.
- R4: `req_dir_wr`=0 (second opcode byte 0x21) is a read: `rsp_gpr_we` rises with the data. `req_dir_wr`=1 (second opcode byte 0x23) is a write: `rsp_gpr_we` stays low.
- R5: With `req_dbg_ext`=0, index 4 addresses register 6 and index 5 addresses register 7, for both reads and writes.
- R6: With `req_dbg_ext`=1, a privileged request with mod=11 that names index 4 or 5 reports the undefined-opcode fault (code 2) and changes no register.
- R7: A request with `req_cpl`≠0 and `req_real_mode`=0 reports the general-protection fault (code 1, error code zero implied). Fault code 0 means no fault.
- R8: When the privilege check fails together with any undefined-opcode cause, the general-protection fault is reported.
- R9: A privileged request whose mod field (ModR/M bits [7:6]) is not 11 reports the undefined-opcode fault (code 2).
- R10: A faulting request updates no register, keeps `rsp_gpr_we` low and returns zero on `rsp_rdata`.
- R11: `rsp_valid` follows `req_valid` in the same cycle, and permitted read data is available combinationally in that cycle. With no request, `rsp_gpr_we` is low.
- R12: A permitted write updates the selected register at the next rising edge, and a read in the following cycle returns the new value.
- R13: `req_ready` is always high, so a request is accepted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high: the unit never stalls |
| req_dir_wr | input | 1 | 1 = general-purpose to debug register (0x23); 0 = debug register to general-purpose (0x21) |
| req_modrm | input | 8 | ModR/M byte: mod [7:6], debug index [5:3], GPR index [2:0] |
| req_cpl | input | 2 | Current privilege level |
| req_real_mode | input | 1 | Real-address mode active |
| req_dbg_ext | input | 1 | Debug-extension enable |
| req_wdata | input | 32 | Data from the general-purpose register |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Debug register contents for a permitted read, else zero |
| rsp_gpr_idx | output | 3 | General-purpose register index |
| rsp_gpr_we | output | 1 | Load the general-purpose register |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 undefined opcode |

## Verification
On every cycle, the assertions check the fault rules for privilege, mod field and folded indices, including the priority of the protection fault. They also check that faults suppress the GPR write and leave the register array unchanged, that the GPR index is passed through, and that each permitted write lands at the next edge. The bench sweeps every combination of privilege, real mode, extension flag, mod field, register index and direction against a shadow model. Only these scenarios can show that the stored values survive across many requests and that folded indices really share storage with registers 6 and 7. They also cover the reset contents and the full-width data patterns.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  // ModR/M layout is fixed by the instruction encoding
  localparam int unsigned IDX_W = 3;
  localparam logic [1:0]  MOD_REG_FORM = 2'b11;
endpackage

// File: rtl/dbgreg_decode.sv
module dbgreg_decode
  import dbgreg_pkg::*;
#(
  parameter int unsigned ALIAS_BASE  = 4,
  parameter int unsigned ALIAS_SHIFT = 2
) (
  input  logic [7:0]       modrm,
  input  logic [1:0]       cpl,
  input  logic             real_mode,
  input  logic             dbg_ext,
  output fault_e           fault,
  output logic [IDX_W-1:0] dr_idx,
  output logic [IDX_W-1:0] gpr_idx
);
  localparam logic [IDX_W-1:0] ALIAS_LO = IDX_W'(ALIAS_BASE);
  localparam logic [IDX_W-1:0] ALIAS_HI = IDX_W'(ALIAS_BASE + 1);
  localparam logic [IDX_W-1:0] SHIFT_V  = IDX_W'(ALIAS_SHIFT);

  logic [1:0]       mod_f;
  logic [IDX_W-1:0] raw_idx;
  logic             priv_ok;
  logic             in_alias;

  assign mod_f    = modrm[7:6];
  assign raw_idx  = modrm[5:3];
  assign gpr_idx  = modrm[2:0];
  assign priv_ok  = (cpl == 2'd0) || real_mode;
  assign in_alias = (raw_idx == ALIAS_LO) || (raw_idx == ALIAS_HI);

  // Folding applies only in legacy mode; in extended mode the fault blocks use
  assign dr_idx = (in_alias && !dbg_ext) ? raw_idx + SHIFT_V : raw_idx;

  always_comb begin
    if (!priv_ok)                    fault = FLT_GP;
    else if (mod_f != MOD_REG_FORM)  fault = FLT_UD;
    else if (dbg_ext && in_alias)    fault = FLT_UD;
    else                             fault = FLT_NONE;
  end
endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [AW-1:0]          rd_idx,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] slot_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(k));
    always_ff @(posedge clk) begin
      if (rst)      slot_q[k] <= '0;
      else if (hit) slot_q[k] <= wr_data;
    end
    assign regs_flat[k*DATA_W +: DATA_W] = slot_q[k];
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/dbgreg_access_unit.sv
module dbgreg_access_unit
  import dbgreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NREG  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dir_wr,
  input  logic [7:0]        req_modrm,
  input  logic [1:0]        req_cpl,
  input  logic              req_real_mode,
  input  logic              req_dbg_ext,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [IDX_W-1:0]  rsp_gpr_idx,
  output logic              rsp_gpr_we,
  output logic [1:0]        rsp_fault
);
  fault_e                   dec_fault;
  logic [IDX_W-1:0]         dr_idx;
  logic [IDX_W-1:0]         gpr_idx;
  logic                     wr_fire;
  logic                     rd_ok;
  logic [DATA_W-1:0]        rd_data;
  logic [NREG*DATA_W-1:0]   regs_flat;

  dbgreg_decode u_dec (
    .modrm     (req_modrm),
    .cpl       (req_cpl),
    .real_mode (req_real_mode),
    .dbg_ext   (req_dbg_ext),
    .fault     (dec_fault),
    .dr_idx    (dr_idx),
    .gpr_idx   (gpr_idx)
  );

  assign wr_fire = req_valid &&  req_dir_wr && (dec_fault == FLT_NONE);
  assign rd_ok   = req_valid && !req_dir_wr && (dec_fault == FLT_NONE);

  dbgreg_file #(.NREG(NREG), .DATA_W(DATA_W)) u_file (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_fire),
    .wr_idx    (dr_idx),
    .wr_data   (req_wdata),
    .rd_idx    (dr_idx),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  assign req_ready   = 1'b1;
  assign rsp_valid   = req_valid;
  assign rsp_rdata   = rd_ok ? rd_data : '0;
  assign rsp_gpr_we  = rd_ok;
  assign rsp_gpr_idx = gpr_idx;
  assign rsp_fault   = req_valid ? dec_fault : FLT_NONE;
endmodule

// File: rtl/dbgreg_access_unit_chk.sv
module dbgreg_access_unit_chk
  import dbgreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_dir_wr,
  input logic [7:0]             req_modrm,
  input logic [1:0]             req_cpl,
  input logic                   req_real_mode,
  input logic                   req_dbg_ext,
  input logic [DATA_W-1:0]      req_wdata,
  input logic                   rsp_gpr_we,
  input logic [IDX_W-1:0]       rsp_gpr_idx,
  input logic [1:0]             rsp_fault,
  input logic [IDX_W-1:0]       dr_idx,
  input logic [NREG*DATA_W-1:0] regs_flat
);
  logic             priv;
  logic             idx45;
  logic             pend;
  logic [IDX_W-1:0] pend_idx;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] pend_word;

  assign priv  = (req_cpl == 2'd0) || req_real_mode;
  assign idx45 = (req_modrm[5:3] == 3'd4) || (req_modrm[5:3] == 3'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      pend      <= req_valid && req_dir_wr && (rsp_fault == FLT_NONE);
      pend_idx  <= dr_idx;
      pend_data <= req_wdata;
    end
  end

  assign pend_word = regs_flat[pend_idx*DATA_W +: DATA_W];

  a_r7_priv_gp: assert property (@(posedge clk) disable iff (rst)
    req_valid && !priv |-> rsp_fault == FLT_GP);

  a_r9_mod_ud: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv && req_modrm[7:6] != 2'b11 |-> rsp_fault == FLT_UD);

  a_r6_ext_ud: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv && req_modrm[7:6] == 2'b11 && req_dbg_ext && idx45
    |-> rsp_fault == FLT_UD);

  a_r10_no_we: assert property (@(posedge clk) disable iff (rst)
    rsp_fault != FLT_NONE |-> !rsp_gpr_we);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_fault != FLT_NONE |=> $stable(regs_flat));

  a_r12_landed: assert property (@(posedge clk) disable iff (rst)
    pend |-> pend_word == pend_data);

  a_r3_gpr_idx: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> rsp_gpr_idx == req_modrm[2:0]);

  a_r4_we_dir: assert property (@(posedge clk) disable iff (rst)
    rsp_gpr_we |-> req_valid && !req_dir_wr);
endmodule

bind dbgreg_access_unit dbgreg_access_unit_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_dir_wr    (req_dir_wr),
  .req_modrm     (req_modrm),
  .req_cpl       (req_cpl),
  .req_real_mode (req_real_mode),
  .req_dbg_ext   (req_dbg_ext),
  .req_wdata     (req_wdata),
  .rsp_gpr_we    (rsp_gpr_we),
  .rsp_gpr_idx   (rsp_gpr_idx),
  .rsp_fault     (rsp_fault),
  .dr_idx        (dr_idx),
  .regs_flat     (regs_flat)
);

// File: tb/dbgreg_access_unit_bench.sv
module dbgreg_access_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_dir_wr;
  logic [7:0]  req_modrm;
  logic [1:0]  req_cpl;
  logic        req_real_mode;
  logic        req_dbg_ext;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [2:0]  rsp_gpr_idx;
  logic        rsp_gpr_we;
  logic [1:0]  rsp_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] model [8];

  always #(CLK_P/2) clk = ~clk;

  dbgreg_access_unit u_dbgreg_access_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_dir_wr(req_dir_wr), .req_modrm(req_modrm), .req_cpl(req_cpl),
    .req_real_mode(req_real_mode), .req_dbg_ext(req_dbg_ext),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_gpr_idx(rsp_gpr_idx), .rsp_gpr_we(rsp_gpr_we), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = '0;
  endtask

  // One request: drive after a falling edge, sample before the next rising edge
  task automatic do_req(input logic wr, input logic [1:0] md, input logic [2:0] idx,
                        input logic [2:0] rm, input logic [1:0] cpl, input logic rl,
                        input logic ext, input logic [31:0] wd);
    logic [1:0] ef;
    logic       priv, a45;
    logic [2:0] eidx;
    string      tg;
    @(negedge clk);
    req_valid = 1'b1; req_dir_wr = wr; req_modrm = {md, idx, rm};
    req_cpl = cpl; req_real_mode = rl; req_dbg_ext = ext; req_wdata = wd;
    #1;
    priv = (cpl == 0) || rl;
    a45  = (idx == 3'd4) || (idx == 3'd5);
    eidx = (a45 && !ext) ? idx + 3'd2 : idx;
    if (!priv)                ef = 2'd1;
    else if (md != 2'b11)     ef = 2'd2;
    else if (ext && a45)      ef = 2'd2;
    else                      ef = 2'd0;
    if (!priv)                tg = (md != 2'b11 || (ext && a45)) ? "R8" : "R7";
    else if (md != 2'b11)     tg = "R9";
    else if (ext && a45)      tg = "R6";
    else                      tg = "R3";
    chk({tg, " fault"}, 32'(rsp_fault), 32'(ef));
    chk("R3 gpr index", 32'(rsp_gpr_idx), 32'(rm));
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R13 ready", 32'(req_ready), 32'd1);
    chk(ef != 0 ? "R10 gpr_we" : "R4 gpr_we", 32'(rsp_gpr_we), 32'(!wr && ef == 0));
    chk(ef != 0 ? "R10 rdata" : (a45 ? "R5 rdata" : "R12 rdata"),
        rsp_rdata, (!wr && ef == 0) ? model[eidx] : 32'd0);
    if (wr && ef == 0) model[eidx] = wd;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n = 0;
    rst = 1'b1; req_valid = 1'b0; req_dir_wr = 1'b0; req_modrm = '0;
    req_cpl = '0; req_real_mode = 1'b0; req_dbg_ext = 1'b0; req_wdata = '0;
    do_reset();
    // R1: all slots read zero after reset
    for (int k = 0; k < 8; k++) begin
      do_req(1'b0, 2'b11, 3'(k), 3'(k), 2'd0, 1'b0, 1'b1, 32'd0);
      chk("R1 reset value", rsp_rdata, 32'd0);
    end
    // R2: full-width patterns
    do_req(1'b1, 2'b11, 3'd0, 3'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    do_req(1'b0, 2'b11, 3'd0, 3'd2, 2'd0, 1'b0, 1'b0, 32'd0);
    chk("R2 all ones", rsp_rdata, 32'hFFFF_FFFF);
    do_req(1'b1, 2'b11, 3'd3, 3'd1, 2'd0, 1'b0, 1'b0, 32'h8000_0001);
    do_req(1'b0, 2'b11, 3'd3, 3'd2, 2'd0, 1'b0, 1'b0, 32'd0);
    chk("R2 edge bits", rsp_rdata, 32'h8000_0001);
    // Sweep: every write is followed at once by a read of the same index
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++)
          for (int m = 0; m < 4; m++)
            for (int x = 0; x < 8; x++)
              for (int d = 1; d >= 0; d--) begin
                n++;
                do_req(d[0], 2'(m), 3'(x), 3'(7 - x), 2'(c), r[0], e[0],
                       {n[15:0] ^ 16'hA5C3, ~n[15:0]});
              end
    // R5: folded indices share storage with 6 and 7
    do_req(1'b1, 2'b11, 3'd4, 3'd0, 2'd0, 1'b0, 1'b0, 32'h1234_5678);
    do_req(1'b0, 2'b11, 3'd6, 3'd0, 2'd0, 1'b0, 1'b1, 32'd0);
    chk("R5 alias 4 to 6", rsp_rdata, 32'h1234_5678);
    // R6 and R10: extended-mode write to 5 leaves 7 alone
    do_req(1'b1, 2'b11, 3'd5, 3'd0, 2'd0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    do_req(1'b0, 2'b11, 3'd7, 3'd0, 2'd0, 1'b0, 1'b1, 32'd0);
    chk("R6 no change", rsp_rdata, model[7]);
    // R11: idle cycle
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R11 idle valid", 32'(rsp_valid), 32'd0);
    chk("R11 idle we", 32'(rsp_gpr_we), 32'd0);
    // R1: reset after traffic
    do_reset();
    for (int k = 0; k < 8; k++) begin
      do_req(1'b0, 2'b11, 3'(k), 3'd0, 2'd3, 1'b1, 1'b1, 32'd0);
      chk("R1 reset after use", rsp_rdata, 32'd0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule